// File: doc/BRIEF.md
# Serial Word Packer with FIFOs and Status Flags

This block sits between a 32-bit host data port and a serial shifter. Host words written for transmission go into an output FIFO. Their bytes are taken left-aligned, so the first byte sits in bits 31:24. The shifter receives each word right-aligned, trimmed to the active serial word size. Words coming back from the shifter are trimmed to that same size and go into an input FIFO, where the host reads them right-aligned. The serial word size is derived from the programmed bit length.

Two counters follow the transfer: one counts words handed to the shifter and the other counts words accepted from it. Each raises a sticky done flag when it reaches the programmed word count. The block also provides:
- live full and not-empty bits for both FIFOs;
- event-driven service requests;
- four sticky over/underrun errors.

All sticky bits are cleared by writing ones. A level interrupt combines the sticky operational bits with the error bits that are enabled. A mode output tells the host whether the word count fits inside one input FIFO. If it does, the transfer runs in FIFO mode; otherwise it runs in block mode.

Top module: `wpk_top`

## Requirements
- R1: The serial word size is 1 byte for `cfg_bits` of 8 or less, 2 bytes for 9 to 16, and 4 bytes above 16.
- R2: In a transmit host word, byte k sits at bits 8*(3-k). `sh_tx_data` presents the head word right-aligned with the first byte most significant:
  - 1-byte size: `{24'h0, w[31:24]}`
  - 2-byte size: `{16'h0, w[31:16]}`
  - 4-byte size: `w`
- R3: A received shifter word is right-aligned and trimmed to the word size on entry; bytes above the size read as zero. The host sees the head on `host_rdata` and pops it with `host_rd`.
- R4: `op_flags` uses this layout. Bits 7:4 are live, taken from the registered FIFO levels:
  - bit 11: input done
  - bit 10: output done
  - bit 9: input service
  - bit 8: output service
  - bit 7: input full
  - bit 6: output full
  - bit 5: input not-empty
  - bit 4: output not-empty
- R5: A host write while the output FIFO is full drops the word and sets `err_flags` bit 5 (output overrun) at the next edge.
- R6: A host read of an empty input FIFO returns zero on `host_rdata` and sets `err_flags` bit 4 (input underrun).
- R7: A shifter request on an empty output FIFO sees `sh_tx_data` of zero and sets `err_flags` bit 3 (output underrun).
- R8: A shifter word arriving while the input FIFO is full is dropped and sets `err_flags` bit 2 (input overrun).
- R9: Both service flags are sticky and are set one clock after their condition rises:
  - input service (bit 9): the input FIFO level rises to at least `BLK` words.
  - output service (bit 8): the free space in the output FIFO rises to at least `BLK` words.
- R10: `start` zeroes both word counters and clears both done flags. Each accepted word advances its counter until the counter equals `cfg_count`. The done flag of a direction is set at the edge where its counter reaches a nonzero `cfg_count`.
- R11: For the sticky bits of `op_flags` (11:8) and all of `err_flags`:
  - A clear write with a one in a bit position clears that bit; a zero leaves the bit unchanged.
  - A set in the same cycle wins over the clear.
  - Live bits 7:4 are unaffected by clear writes.
- R12: `irq` is high while any of these holds: an error bit is set together with its enable in `err_en`, or any of `op_flags` bits 11:8 is set.
- R13: `blk_mode` is 1 when `cfg_count` exceeds the input FIFO depth, else 0 (FIFO mode).
- R14: After reset both flag words are zero, `irq` is low and `host_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bits | input | 6 | Serial word length in bits (1..32) |
| cfg_count | input | CNT_W | Programmed word count of the transfer |
| start | input | 1 | Zeroes counters and clears done flags |
| host_wr | input | 1 | Push a host word into the output FIFO |
| host_wdata | input | 32 | Host word, bytes left-aligned |
| host_rd | input | 1 | Pop the input FIFO head |
| host_rdata | output | 32 | Input FIFO head, right-aligned, zero when empty |
| sh_tx_req | input | 1 | Shifter takes the output FIFO head |
| sh_tx_data | output | 32 | Output FIFO head, right-aligned for the shifter |
| sh_rx_valid | input | 1 | Shifter delivers a received word |
| sh_rx_data | input | 32 | Received word, right-aligned |
| op_clr_wr | input | 1 | Clear strobe for operational flags |
| op_clr_data | input | 32 | Ones clear matching sticky operational bits |
| err_clr_wr | input | 1 | Clear strobe for error flags |
| err_clr_data | input | 32 | Ones clear matching error bits |
| err_en | input | 32 | Interrupt enables aligned to `err_flags` |
| op_flags | output | 32 | Operational flag word |
| err_flags | output | 32 | Error flag word |
| irq | output | 1 | Level interrupt |
| blk_mode | output | 1 | 1 when the count exceeds the input FIFO depth |

## Verification
A FIFO level that drifts from the real contents shows on the full and not-empty bits at the very next edge. It also appears as a wrong word or a spurious zero on `sh_tx_data` or `host_rdata` when that entry reaches the head, so draining every FIFO after overflow exposes a dropped or duplicated word. A counter that is off by one moves the rise of a done flag one word early or late, and the bench checks the flag before and after the final word. A wrong service edge detector leaves a service bit unset or sets it out of turn; this shows within two cycles of the level crossing and is checked by filling and draining past `BLK`.

// File: rtl/wpk_pkg.sv
package wpk_pkg;

  // Serial word size in bytes from the bit length (R1)
  function automatic logic [2:0] wpk_bytes(input logic [5:0] bits);
    if (bits <= 6'd8)       return 3'd1;
    else if (bits <= 6'd16) return 3'd2;
    else                    return 3'd4;
  endfunction

  // Host word with bytes from the top down -> right-aligned serial word (R2)
  function automatic logic [31:0] wpk_tx_align(input logic [31:0] w, input logic [2:0] nb);
    case (nb)
      3'd1:    return {24'h0, w[31:24]};
      3'd2:    return {16'h0, w[31:16]};
      default: return w;
    endcase
  endfunction

  // Received word trimmed to the serial word size (R3)
  function automatic logic [31:0] wpk_rx_trim(input logic [31:0] w, input logic [2:0] nb);
    case (nb)
      3'd1:    return {24'h0, w[7:0]};
      3'd2:    return {16'h0, w[15:0]};
      default: return w;
    endcase
  endfunction

  // Index of each sticky bit inside its 4-bit group
  localparam int OP_IN_DONE  = 3;  // op_flags bit 11
  localparam int OP_OUT_DONE = 2;  // op_flags bit 10
  localparam int OP_IN_SVC   = 1;  // op_flags bit 9
  localparam int OP_OUT_SVC  = 0;  // op_flags bit 8
  localparam int ER_OUT_OVR  = 3;  // err_flags bit 5
  localparam int ER_IN_UND   = 2;  // err_flags bit 4
  localparam int ER_OUT_UND  = 1;  // err_flags bit 3
  localparam int ER_IN_OVR   = 0;  // err_flags bit 2

endpackage

// File: rtl/wpk_fifo.sv
module wpk_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign full    = (level == LVL_W'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH)); // R5

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full); // R8
endmodule

// File: rtl/wpk_sticky.sv
module wpk_sticky #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  // Set wins over clear in the same cycle (R11)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr) | set;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((q & $past(set)) == $past(set))); // R11
endmodule

// File: rtl/wpk_top.sv
module wpk_top
  import wpk_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int BLK   = 4,
  parameter int CNT_W = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       cfg_bits,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             start,
  input  logic             host_wr,
  input  logic [31:0]      host_wdata,
  input  logic             host_rd,
  output logic [31:0]      host_rdata,
  input  logic             sh_tx_req,
  output logic [31:0]      sh_tx_data,
  input  logic             sh_rx_valid,
  input  logic [31:0]      sh_rx_data,
  input  logic             op_clr_wr,
  input  logic [31:0]      op_clr_data,
  input  logic             err_clr_wr,
  input  logic [31:0]      err_clr_data,
  input  logic [31:0]      err_en,
  output logic [31:0]      op_flags,
  output logic [31:0]      err_flags,
  output logic             irq,
  output logic             blk_mode
);
  logic [2:0]       nbytes;
  logic [31:0]      out_head, in_head;
  logic [LVL_W-1:0] out_lvl, in_lvl;
  logic             out_full, out_empty, in_full, in_empty;

  assign nbytes = wpk_bytes(cfg_bits);

  wpk_fifo #(.DEPTH(DEPTH), .W(32)) u_out_fifo (
    .clk(clk), .rst_n(rst_n), .push(host_wr), .wdata(host_wdata),
    .pop(sh_tx_req), .head(out_head), .level(out_lvl),
    .full(out_full), .empty(out_empty));

  wpk_fifo #(.DEPTH(DEPTH), .W(32)) u_in_fifo (
    .clk(clk), .rst_n(rst_n), .push(sh_rx_valid), .wdata(wpk_rx_trim(sh_rx_data, nbytes)),
    .pop(host_rd), .head(in_head), .level(in_lvl),
    .full(in_full), .empty(in_empty));

  assign sh_tx_data = out_empty ? 32'h0 : wpk_tx_align(out_head, nbytes);
  assign host_rdata = in_empty  ? 32'h0 : in_head;

  // Named events
  logic ev_out_ovr, ev_in_und, ev_out_und, ev_in_ovr, ev_tx_word, ev_rx_word;
  assign ev_out_ovr = host_wr && out_full;
  assign ev_in_und  = host_rd && in_empty;
  assign ev_out_und = sh_tx_req && out_empty;
  assign ev_in_ovr  = sh_rx_valid && in_full;
  assign ev_tx_word = sh_tx_req && !out_empty;
  assign ev_rx_word = sh_rx_valid && !in_full;

  // Transfer counters
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic             tx_more, rx_more, ev_tx_done, ev_rx_done;
  assign tx_more    = (tx_cnt != cfg_count);
  assign rx_more    = (rx_cnt != cfg_count);
  assign ev_tx_done = !start && ev_tx_word && tx_more && (cfg_count != '0) &&
                      (tx_cnt + CNT_W'(1) == cfg_count);
  assign ev_rx_done = !start && ev_rx_word && rx_more && (cfg_count != '0) &&
                      (rx_cnt + CNT_W'(1) == cfg_count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_cnt <= '0;
      rx_cnt <= '0;
    end else if (start) begin
      tx_cnt <= '0;
      rx_cnt <= '0;
    end else begin
      if (ev_tx_word && tx_more) tx_cnt <= tx_cnt + 1'b1;
      if (ev_rx_word && rx_more) rx_cnt <= rx_cnt + 1'b1;
    end
  end

  // Service edge detectors (empty output FIFO has room at reset)
  logic in_svc_cond, out_svc_cond, in_svc_prev, out_svc_prev;
  assign in_svc_cond  = (in_lvl >= LVL_W'(BLK));
  assign out_svc_cond = ((LVL_W'(DEPTH) - out_lvl) >= LVL_W'(BLK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_svc_prev  <= 1'b0;
      out_svc_prev <= 1'b1;
    end else begin
      in_svc_prev  <= in_svc_cond;
      out_svc_prev <= out_svc_cond;
    end
  end

  // Sticky flag groups
  logic [3:0] op_set, op_clr, op_q, er_set, er_clr, er_q;
  always_comb begin
    op_set = '0;
    op_set[OP_IN_DONE]  = ev_rx_done;
    op_set[OP_OUT_DONE] = ev_tx_done;
    op_set[OP_IN_SVC]   = in_svc_cond && !in_svc_prev;
    op_set[OP_OUT_SVC]  = out_svc_cond && !out_svc_prev;
    op_clr = op_clr_wr ? op_clr_data[11:8] : 4'h0;
    if (start) begin
      op_clr[OP_IN_DONE]  = 1'b1;
      op_clr[OP_OUT_DONE] = 1'b1;
    end
    er_set = '0;
    er_set[ER_OUT_OVR] = ev_out_ovr;
    er_set[ER_IN_UND]  = ev_in_und;
    er_set[ER_OUT_UND] = ev_out_und;
    er_set[ER_IN_OVR]  = ev_in_ovr;
    er_clr = err_clr_wr ? err_clr_data[5:2] : 4'h0;
  end

  wpk_sticky #(.W(4)) u_op_flags  (.clk(clk), .rst_n(rst_n), .set(op_set), .clr(op_clr), .q(op_q));
  wpk_sticky #(.W(4)) u_err_flags (.clk(clk), .rst_n(rst_n), .set(er_set), .clr(er_clr), .q(er_q));

  assign op_flags  = {20'h0, op_q, in_full, out_full, !in_empty, !out_empty, 4'h0};
  assign err_flags = {26'h0, er_q, 2'b00};
  assign irq       = (|(err_flags & err_en)) || (|op_q);
  assign blk_mode  = (cfg_count > CNT_W'(DEPTH));

  AST_OUT_OVR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && out_full) |=> err_flags[5]); // R5
  AST_IN_UND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && in_empty) |-> (host_rdata == 32'h0)); // R6
  AST_OUT_UND_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_tx_req && out_empty) |=> err_flags[3]); // R7
  AST_IN_OVR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_rx_valid && in_full) |=> err_flags[2]); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_flags[10] && !start && !(op_clr_wr && op_clr_data[10])) |=> op_flags[10]); // R10
endmodule

// File: tb/wpk_top_tb.sv
`timescale 1ns/1ps
module wpk_top_tb;
  localparam int DEPTH = 8;
  localparam int CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] cfg_bits;
  logic [CNT_W-1:0] cfg_count;
  logic start, host_wr, host_rd, sh_tx_req, sh_rx_valid, op_clr_wr, err_clr_wr, irq, blk_mode;
  logic [31:0] host_wdata, host_rdata, sh_tx_data, sh_rx_data, op_clr_data, err_clr_data;
  logic [31:0] err_en, op_flags, err_flags;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  wpk_top #(.DEPTH(DEPTH), .BLK(4), .CNT_W(CNT_W)) u_dut (.*);

  // {rx direction, bits, input word, expected word}
  localparam logic [70:0] VEC [11] = '{
    {1'b0, 6'd8,  32'hA1B2C3D4, 32'h000000A1},  // R1 R2
    {1'b0, 6'd4,  32'hA1B2C3D4, 32'h000000A1},  // R1
    {1'b0, 6'd9,  32'hA1B2C3D4, 32'h0000A1B2},  // R1
    {1'b0, 6'd16, 32'h11223344, 32'h00001122},  // R2
    {1'b0, 6'd17, 32'h11223344, 32'h11223344},  // R1
    {1'b0, 6'd32, 32'hCAFEF00D, 32'hCAFEF00D},  // R2
    {1'b1, 6'd8,  32'h12345678, 32'h00000078},  // R3
    {1'b1, 6'd16, 32'h12345678, 32'h00005678},  // R3
    {1'b1, 6'd32, 32'h12345678, 32'h12345678},  // R3
    {1'b1, 6'd12, 32'h0000ABCD, 32'h0000ABCD},  // R1
    {1'b1, 6'd5,  32'hFFFFFF9E, 32'h0000009E}   // R1 R3
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    op_clr_wr = 1; op_clr_data = '1; err_clr_wr = 1; err_clr_data = '1;
    tick();
    op_clr_wr = 0; err_clr_wr = 0;
  endtask

  initial begin
    #(5ns * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cfg_bits = 6'd32; cfg_count = 16'd1000; start = 0;
    host_wr = 0; host_wdata = 0; host_rd = 0; sh_tx_req = 0; sh_rx_valid = 0; sh_rx_data = 0;
    op_clr_wr = 0; op_clr_data = 0; err_clr_wr = 0; err_clr_data = 0; err_en = 0;
    tick(); tick();
    rst_n = 1;
    tick();
    chk("R14 op_flags", op_flags, 32'h0);
    chk("R14 err_flags", err_flags, 32'h0);
    chk("R14 irq", {31'h0, irq}, 32'h0);
    chk("R14 host_rdata", host_rdata, 32'h0);
    chk("R13 blk_mode count 1000", {31'h0, blk_mode}, 32'h1);
    start = 1; tick(); start = 0;

    // Table walk
    foreach (VEC[i]) begin
      cfg_bits = VEC[i][69:64];
      if (!VEC[i][70]) begin
        host_wr = 1; host_wdata = VEC[i][63:32]; tick(); host_wr = 0;
        chk("R2 tx align", sh_tx_data, VEC[i][31:0]);
        sh_tx_req = 1; tick(); sh_tx_req = 0;
      end else begin
        sh_rx_valid = 1; sh_rx_data = VEC[i][63:32]; tick(); sh_rx_valid = 0;
        chk("R3 rx trim", host_rdata, VEC[i][31:0]);
        host_rd = 1; tick(); host_rd = 0;
      end
    end
    cfg_bits = 6'd32;
    clear_all();

    // Output overrun and drop
    for (int i = 0; i < DEPTH; i++) begin
      host_wr = 1; host_wdata = 32'h100 + i; tick();
    end
    host_wr = 0;
    chk("R4 out full and not-empty", op_flags & 32'h50, 32'h50);
    op_clr_wr = 1; op_clr_data = '1; tick(); op_clr_wr = 0;
    chk("R11 live bits keep", op_flags & 32'hF0, 32'h50);
    host_wr = 1; host_wdata = 32'hDEAD; tick(); host_wr = 0;
    chk("R5 out overrun flag", err_flags, 32'h20);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R5 kept words", sh_tx_data, 32'h100 + i);
      sh_tx_req = 1; tick(); sh_tx_req = 0;
    end
    chk("R5 dropped word absent", op_flags & 32'h10, 32'h0);
    tick();
    chk("R9 out service", op_flags & 32'h100, 32'h100);

    // Output underrun
    chk("R7 empty tx data zero", sh_tx_data, 32'h0);
    sh_tx_req = 1; tick(); sh_tx_req = 0;
    chk("R7 out underrun flag", err_flags, 32'h28);

    // Selective clear
    err_clr_wr = 1; err_clr_data = 32'h20; tick(); err_clr_wr = 0;
    chk("R11 partial clear", err_flags, 32'h08);
    err_clr_wr = 1; err_clr_data = 32'h08; tick(); err_clr_wr = 0;
    chk("R11 clear rest", err_flags, 32'h0);

    // Interrupt masking and input underrun
    clear_all();
    chk("R12 irq low when clear", {31'h0, irq}, 32'h0);
    chk("R6 empty read zero", host_rdata, 32'h0);
    host_rd = 1; tick(); host_rd = 0;
    chk("R6 in underrun flag", err_flags, 32'h10);
    chk("R12 masked error no irq", {31'h0, irq}, 32'h0);
    err_en = 32'h10; #1;
    chk("R12 enabled error irq", {31'h0, irq}, 32'h1);
    err_en = 0;
    clear_all();

    // Input overrun and service
    for (int i = 0; i <= DEPTH; i++) begin
      sh_rx_valid = 1; sh_rx_data = 32'h200 + i; tick();
    end
    sh_rx_valid = 0;
    chk("R4 in full", op_flags & 32'hA0, 32'hA0);
    chk("R8 in overrun flag", err_flags, 32'h04);
    chk("R9 in service", op_flags & 32'h200, 32'h200);
    chk("R12 irq from service", {31'h0, irq}, 32'h1);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R8 kept words", host_rdata, 32'h200 + i);
      host_rd = 1; tick(); host_rd = 0;
    end
    chk("R8 dropped word absent", op_flags & 32'h20, 32'h0);
    clear_all();

    // Done flags
    cfg_count = 16'd3; start = 1; tick(); start = 0;
    chk("R13 fifo mode", {31'h0, blk_mode}, 32'h0);
    for (int i = 0; i < 3; i++) begin
      host_wr = 1; host_wdata = i; tick(); host_wr = 0;
      sh_tx_req = 1; tick(); sh_tx_req = 0;
      chk("R10 out done timing", op_flags & 32'h400, (i == 2) ? 32'h400 : 32'h0);
    end
    for (int i = 0; i < 3; i++) begin
      sh_rx_valid = 1; sh_rx_data = i; tick(); sh_rx_valid = 0;
      chk("R10 in done timing", op_flags & 32'h800, (i == 2) ? 32'h800 : 32'h0);
      host_rd = 1; tick(); host_rd = 0;
    end
    start = 1; tick(); start = 0;
    chk("R10 start clears done", op_flags & 32'hC00, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule